// File: doc/BRIEF.md
# Timer Slave-Mode Trigger Controller

This block is a 16-bit up-counter with a prescaler and a reload limit. An external trigger decides when the counter runs, stops, restarts or advances. A slave controller reads a 4-bit mode code and applies the trigger in one of five ways. The trigger can restart the count, gate the internal clock, set the run bit, act as the count clock, or restart the count and set the run bit together. Codes that are not defined leave the counter running from the internal clock under its run bit.

The trigger comes from one of two sources. The first is a level input that passes through a synchronizer. The second is a pulse that input 1 produces on each of its transitions. Software sets the run bit, the mode code, the trigger source, the prescaler and the reload limit through a word-addressed write port. New prescaler and reload values wait in pending registers. They move into the active copies only on an update event. An update event is either a wrap at the reload limit or a trigger restart.

Top module: `tsc_timer`

## Requirements
- R1: After reset the counter reads 0, the run bit is 0, the update output is 0 and the error output is 0. The active reload limit is all ones and the active prescaler is 0.
- R2: Writes go by word address. Address 0 bit 0 is the run bit. Address 1 holds the mode code: bits 2:0 are its low three bits and bit 16 is its top bit. Bit 4 of address 1 selects the trigger source: 0 is the synchronized level input, 1 is the input-1 transition pulse. Address 2 is the pending prescaler and address 3 is the pending reload limit.
- R3: On every step it is allowed to take, the counter advances by one after prescaler+1 enabled cycles. At the active reload limit it goes to 0 instead, and the update output is high for exactly one cycle. Each update event copies the pending prescaler and reload limit into the active copies.
- R4: Mode 0000, and every undefined code (0001 to 0011, 1001 to 1111), count on the internal clock while the run bit is 1. In these modes the trigger has no effect.
- R5: In mode 0100, a trigger rising edge clears the counter and the prescaler and raises an update event. The run bit does not change.
- R6: In mode 0101, the counter advances only in cycles where the run bit is 1 and the trigger is high. While the trigger is low the counter keeps its value.
- R7: In mode 0110, a trigger rising edge sets the run bit without clearing the counter. A later falling edge leaves the run bit set.
- R8: In mode 0111 with the run bit set, each trigger rising edge counts as one prescaler input cycle in place of the internal clock.
- R9: In mode 1000, a single trigger rising edge clears the counter, raises an update event and sets the run bit.
- R10: The level input passes through two flops, and the rising edge is found on the synchronized signal. When trig_in rises just before clock edge N, the effect of the edge shows at the outputs after edge N+2.
- R11: With source 1 selected, every transition of input 1, rising or falling, gives one single-cycle trigger pulse and therefore one rising edge.
- R12: The error output is 1 exactly while mode 0101 is selected together with the transition-pulse source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Word address of the write |
| wr_data | input | 32 | Write data |
| trig_in | input | 1 | Asynchronous level trigger input |
| ch1_in | input | 1 | Asynchronous input 1, feeds the transition detector |
| cnt_out | output | 16 | Counter value |
| upd_evt | output | 1 | One-cycle update event pulse |
| run_o | output | 1 | Current run bit |
| cfg_err | output | 1 | Set while gated mode uses the transition-pulse source |

## Verification
The bench targets the split mode field. It writes the code 1100, which must decode as undefined; a decoder that ignored bit 16 would see reset mode and clear the counter on a trigger edge. It checks that gated mode holds the count and does not clear it, and that a falling edge in trigger mode leaves the run bit set. A design that copied the shadows at the wrong moment would wrap at a stale limit, so the bench checks that. It times the two-flop trigger latency to the exact cycle. It also feeds transitions in both directions on input 1, so a detector that responded to rising transitions only would lose half the counts.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
    typedef enum logic [2:0] {
        SM_OFF, SM_RESET, SM_GATED, SM_TRIG, SM_EXTCLK, SM_COMBO
    } sm_mode_e;

    localparam logic [1:0] ADDR_CTRL  = 2'd0;
    localparam logic [1:0] ADDR_SLAVE = 2'd1;
    localparam logic [1:0] ADDR_PSC   = 2'd2;
    localparam logic [1:0] ADDR_ARR   = 2'd3;

    // undefined codes fold into the disabled behaviour
    function automatic sm_mode_e sm_decode(input logic [3:0] code);
        case (code)
            4'b0100: return SM_RESET;
            4'b0101: return SM_GATED;
            4'b0110: return SM_TRIG;
            4'b0111: return SM_EXTCLK;
            4'b1000: return SM_COMBO;
            default: return SM_OFF;
        endcase
    endfunction
endpackage

// File: rtl/tsc_sync.sv
module tsc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb sh_d = {sh_q[STAGES-2:0], d_i};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/tsc_trig_sel.sv
module tsc_trig_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    input  logic ch1_i,
    input  logic sel_edge_i,
    output logic trgi_o,
    output logic rise_o
);
    typedef struct packed {
        logic ch1_prev;
        logic trgi_prev;
    } tsel_t;

    tsel_t st_d, st_q;
    logic  pulse;

    always_comb begin
        pulse  = ch1_i ^ st_q.ch1_prev;
        trgi_o = sel_edge_i ? pulse : lvl_i;
        rise_o = trgi_o & ~st_q.trgi_prev;
        st_d.ch1_prev  = ch1_i;
        st_d.trgi_prev = trgi_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R11
    transition_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_edge_i && (ch1_i != st_q.ch1_prev)) |-> trgi_o);
endmodule

// File: rtl/tsc_regs.sv
module tsc_regs import tsc_pkg::*; #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    parameter int PSC_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              start_i,
    output logic              run_o,
    output sm_mode_e          mode_o,
    output logic              sel_edge_o,
    output logic [PSC_W-1:0]  psc_pend_o,
    output logic [CNT_W-1:0]  arr_pend_o,
    output logic              cfg_err_o
);
    localparam int MODE_HI_BIT = 16;
    localparam int SEL_BIT     = 4;

    typedef struct packed {
        logic             run;
        logic [2:0]       mode_lo;
        logic             mode_hi;
        logic             sel;
        logic [PSC_W-1:0] psc;
        logic [CNT_W-1:0] arr;
    } regs_t;

    regs_t r_d, r_q;
    logic  unused_hi_bits;
    assign unused_hi_bits = ^wr_data[DATA_W-1:MODE_HI_BIT+1];

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (wr_addr)
                ADDR_CTRL:  r_d.run = wr_data[0];
                ADDR_SLAVE: begin
                    r_d.mode_lo = wr_data[2:0];
                    r_d.mode_hi = wr_data[MODE_HI_BIT];
                    r_d.sel     = wr_data[SEL_BIT];
                end
                ADDR_PSC:   r_d.psc = wr_data[PSC_W-1:0];
                default:    r_d.arr = wr_data[CNT_W-1:0];
            endcase
        end
        if (start_i) r_d.run = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{run: 1'b0, mode_lo: 3'd0, mode_hi: 1'b0, sel: 1'b0,
                             psc: '0, arr: '1};
        else        r_q <= r_d;
    end

    assign run_o      = r_q.run;
    assign mode_o     = sm_decode({r_q.mode_hi, r_q.mode_lo});
    assign sel_edge_o = r_q.sel;
    assign psc_pend_o = r_q.psc;
    assign arr_pend_o = r_q.arr;
    assign cfg_err_o  = (mode_o == SM_GATED) && r_q.sel;

    // R7 R9
    start_sets_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> run_o);
endmodule

// File: rtl/tsc_core.sv
module tsc_core import tsc_pkg::*; #(
    parameter int CNT_W = 16,
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  sm_mode_e         mode_i,
    input  logic             trgi_i,
    input  logic             rise_i,
    input  logic [PSC_W-1:0] psc_pend_i,
    input  logic [CNT_W-1:0] arr_pend_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             upd_o,
    output logic             start_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [PSC_W-1:0] pc;
        logic [PSC_W-1:0] psc_act;
        logic [CNT_W-1:0] arr_act;
        logic             upd;
    } core_t;

    core_t st_d, st_q;
    logic  tick, rst_ev, reload;

    always_comb begin
        st_d     = st_q;
        st_d.upd = 1'b0;
        reload   = 1'b0;
        case (mode_i)
            SM_GATED:  tick = run_i & trgi_i;
            SM_EXTCLK: tick = run_i & rise_i;
            default:   tick = run_i;
        endcase
        rst_ev  = rise_i & ((mode_i == SM_RESET) || (mode_i == SM_COMBO));
        start_o = rise_i & ((mode_i == SM_TRIG) || (mode_i == SM_COMBO));
        if (rst_ev) begin
            st_d.cnt = '0;
            st_d.pc  = '0;
            reload   = 1'b1;
        end else if (tick) begin
            if (st_q.pc == st_q.psc_act) begin
                st_d.pc = '0;
                if (st_q.cnt == st_q.arr_act) begin
                    st_d.cnt = '0;
                    reload   = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end else begin
                st_d.pc = st_q.pc + 1'b1;
            end
        end
        if (reload) begin
            st_d.upd     = 1'b1;
            st_d.psc_act = psc_pend_i;
            st_d.arr_act = arr_pend_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: '0, pc: '0, psc_act: '0, arr_act: '1, upd: 1'b0};
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
    assign upd_o = st_q.upd;

    // R3
    within_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_o <= st_q.arr_act);
    // R3
    update_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |-> (cnt_o == '0));
    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == SM_OFF && !run_i) |=> $stable(cnt_o));
    // R6
    gate_low_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == SM_GATED && !trgi_i) |=> $stable(cnt_o));
    // R8
    extclk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == SM_EXTCLK && !rise_i) |=> $stable(cnt_o));
    // R9
    combo_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == SM_COMBO && rise_i) |=> (cnt_o == '0 && upd_o));
endmodule

// File: rtl/tsc_timer.sv
module tsc_timer import tsc_pkg::*; #(
    parameter int CNT_W       = 16,
    parameter int PSC_W       = 16,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              trig_in,
    input  logic              ch1_in,
    output logic [CNT_W-1:0]  cnt_out,
    output logic              upd_evt,
    output logic              run_o,
    output logic              cfg_err
);
    localparam int N_IN = 2;

    logic [N_IN-1:0] raw_in, sync_in;
    logic            sel_edge, trgi, rise, start;
    sm_mode_e        mode;
    logic [PSC_W-1:0] psc_pend;
    logic [CNT_W-1:0] arr_pend;

    assign raw_in = {ch1_in, trig_in};

    for (genvar g = 0; g < N_IN; g++) begin : g_sync
        tsc_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk(clk), .rst_n(rst_n), .d_i(raw_in[g]), .q_o(sync_in[g]));
    end

    tsc_trig_sel u_trig (
        .clk(clk), .rst_n(rst_n), .lvl_i(sync_in[0]), .ch1_i(sync_in[1]),
        .sel_edge_i(sel_edge), .trgi_o(trgi), .rise_o(rise));

    tsc_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .PSC_W(PSC_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .start_i(start), .run_o(run_o), .mode_o(mode),
        .sel_edge_o(sel_edge), .psc_pend_o(psc_pend), .arr_pend_o(arr_pend),
        .cfg_err_o(cfg_err));

    tsc_core #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_core (
        .clk(clk), .rst_n(rst_n), .run_i(run_o), .mode_i(mode), .trgi_i(trgi),
        .rise_i(rise), .psc_pend_i(psc_pend), .arr_pend_i(arr_pend),
        .cnt_o(cnt_out), .upd_o(upd_evt), .start_o(start));
endmodule

// File: tb/tsc_timer_bench.sv
`timescale 1ns/1ps
module tsc_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        trig_in = 1'b0;
    logic        ch1_in = 1'b0;
    logic [15:0] cnt_out;
    logic        upd_evt, run_o, cfg_err;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    string tag = "R1";

    always #2.5 clk = ~clk;

    tsc_timer u_tsc_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .trig_in(trig_in), .ch1_in(ch1_in),
        .cnt_out(cnt_out), .upd_evt(upd_evt), .run_o(run_o), .cfg_err(cfg_err));

    // ---------------- behavioural reference model ----------------
    bit   t1, t2, c1, c2, c3, tq;
    bit   m_run, m_hi, m_sel, m_upd, m_err;
    bit [2:0]  m_lo;
    int   m_psc_p, m_arr_p, m_psc_a, m_arr_a, m_cnt, m_pc;
    bit   trgi, rise, tick, rst_ev, start, reload;
    int   code;

    always @(posedge clk) begin
        if (!rst_n) begin
            {t1, t2, c1, c2, c3, tq} = '0;
            m_run = 0; m_hi = 0; m_sel = 0; m_lo = 0; m_upd = 0; m_err = 0;
            m_psc_p = 0; m_arr_p = 65535; m_psc_a = 0; m_arr_a = 65535;
            m_cnt = 0; m_pc = 0;
        end else begin
            trgi   = m_sel ? (c2 ^ c3) : t2;
            rise   = trgi && !tq;
            code   = m_hi * 8 + m_lo;
            if (code == 5)      tick = m_run && trgi;
            else if (code == 7) tick = m_run && rise;
            else                tick = m_run;
            rst_ev = rise && (code == 4 || code == 8);
            start  = rise && (code == 6 || code == 8);
            reload = 0;
            if (rst_ev) begin
                m_cnt = 0; m_pc = 0; reload = 1;
            end else if (tick) begin
                if (m_pc >= m_psc_a) begin
                    m_pc = 0;
                    if (m_cnt >= m_arr_a) begin m_cnt = 0; reload = 1; end
                    else m_cnt++;
                end else m_pc++;
            end
            m_upd = reload;
            if (reload) begin m_psc_a = m_psc_p; m_arr_a = m_arr_p; end
            if (wr_en) begin
                case (wr_addr)
                    2'd0: m_run = wr_data[0];
                    2'd1: begin m_lo = wr_data[2:0]; m_hi = wr_data[16]; m_sel = wr_data[4]; end
                    2'd2: m_psc_p = wr_data[15:0];
                    default: m_arr_p = wr_data[15:0];
                endcase
            end
            if (start) m_run = 1;
            m_err = ((m_hi * 8 + m_lo) == 5) && m_sel;
            tq = trgi;
            c3 = c2; c2 = c1; c1 = ch1_in;
            t2 = t1; t1 = trig_in;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (cnt_out !== 16'(m_cnt) || upd_evt !== m_upd || run_o !== m_run || cfg_err !== m_err) begin
                errors++;
                $display("FAIL %s: cnt/upd/run/err got %0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d",
                         tag, cnt_out, upd_evt, run_o, cfg_err, m_cnt, m_upd, m_run, m_err);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string rq, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", rq, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    function automatic logic [31:0] sw(input logic [3:0] c, input logic s);
        logic [31:0] w = '0;
        w[2:0] = c[2:0]; w[16] = c[3]; w[4] = s;
        return w;
    endfunction

    task automatic pulse(input int hi, input int lo);
        @(negedge clk); trig_in = 1'b1;
        repeat (hi) @(negedge clk);
        trig_in = 1'b0;
        repeat (lo) @(negedge clk);
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R10: watchdog got timeout expected completion");
        finish_run();
    end

    initial begin : stim
        int v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        tag = "R1";
        chk("R1 count", cnt_out, 0); chk("R1 run", run_o, 0);
        chk("R1 upd", upd_evt, 0);   chk("R1 err", cfg_err, 0);

        tag = "R5";
        wr(2, 1); wr(3, 5); wr(1, sw(4'd4, 0));
        pulse(3, 6);
        chk("R5 idle count", cnt_out, 0);

        tag = "R3";
        wr(1, sw(4'd0, 0)); wr(0, 1);
        repeat (40) @(negedge clk);
        tag = "R4";
        pulse(3, 10);

        wr(0, 0); wr(1, sw(4'd3, 0));
        v = cnt_out;
        pulse(3, 8);
        chk("R4 undefined 0011 ignores trigger", cnt_out, v);
        tag = "R2";
        wr(1, sw(4'd12, 0));
        pulse(3, 8);
        chk("R2 top bit makes 1100 undefined", cnt_out, v);
        wr(1, sw(4'd9, 0));
        pulse(3, 8);
        chk("R4 undefined 1001 ignores trigger", cnt_out, v);

        tag = "R5";
        wr(1, sw(4'd4, 0)); wr(0, 1);
        repeat (5) @(negedge clk);
        pulse(2, 14);

        tag = "R6";
        wr(1, sw(4'd5, 0));
        pulse(7, 4);
        v = cnt_out;
        repeat (3) @(negedge clk);
        chk("R6 gate low holds", cnt_out, v);
        pulse(5, 5);

        tag = "R7";
        wr(0, 0); wr(1, sw(4'd6, 0));
        repeat (4) @(negedge clk);
        chk("R7 stopped before edge", run_o, 0);
        pulse(8, 6);
        chk("R7 edge set run, fall kept it", run_o, 1);
        repeat (10) @(negedge clk);

        tag = "R8";
        wr(1, sw(4'd7, 0));
        for (int i = 0; i < 6; i++) pulse(3, 3);
        v = cnt_out;
        repeat (5) @(negedge clk);
        chk("R8 no edge no step", cnt_out, v);

        tag = "R11";
        wr(1, sw(4'd7, 1));
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); ch1_in = ~ch1_in;
            repeat (6) @(negedge clk);
        end

        tag = "R12";
        wr(1, sw(4'd5, 1));
        chk("R12 gated with pulse source", cfg_err, 1);
        wr(1, sw(4'd5, 0));
        chk("R12 gated with level source", cfg_err, 0);

        tag = "R9";
        wr(0, 0); wr(2, 0); wr(3, 3); wr(1, sw(4'd8, 0));
        pulse(2, 6);
        chk("R9 combined sets run", run_o, 1);
        repeat (20) @(negedge clk);

        tag = "R10";
        wr(0, 0);
        repeat (6) @(negedge clk);
        trig_in = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R10 no effect two edges after rise", upd_evt, 0);
        @(negedge clk);
        chk("R10 effect on third edge", upd_evt, 1);
        trig_in = 1'b0;
        repeat (6) @(negedge clk);

        finish_run();
    end
endmodule